// File: doc/BRIEF.md
# Multi-Word Shift Sequencer

This block performs a 128-bit shift of a latched operand: logical right, arithmetic right, or left. It does not use a 128-bit barrel shifter. A single 32-bit funnel-shift datapath is stepped across the four result words, one word per clock. A right shift produces the least-significant result word first and moves upward. A left shift produces the most-significant word first and moves downward. Each result word is a funnel extract of an adjacent pair of source words, chosen by the whole-word part of the shift amount. Source words that fall outside the operand are replaced by fill. For a left shift and a logical right shift the fill is zero. For an arithmetic right shift the fill is copies of the operand's top bit.

The condition flags are chained from step to step, so the final flags describe the whole 128-bit result. The first step sets every flag and decides carry. Each later step only narrows the zero flag. The step that writes the most-significant word owns sign and overflow: that is the first step of a left shift and the last step of a right shift.

The shift amount passes through one of two modes. Clamp mode limits it to 128. Wrap mode reduces it modulo 128. A caller pulses start with the operand and controls, waits for done, and then reads the result and flags.

Top module: `shf_seq`

## Requirements
- R1: With left_i=0 and arith_i=0, the result equals the operand shifted right by the effective amount, with zero fill.
- R2: With left_i=0 and arith_i=1, vacated upper bits take the value of operand bit 127. An effective amount of 128 gives all copies of that bit.
- R3: With left_i=1, the result equals the operand shifted left by the effective amount, with zero fill, and arith_i has no effect.
- R4: The effective amount is min(amount_i, 128) when clamp_i=1, and amount_i modulo 128 when clamp_i=0. amount_i is 8 bits wide.
- R5: At done, zero_o is 1 exactly when all 128 result bits are 0.
- R6: At done, carry_o is the last bit shifted out, and 0 for an effective amount of 0. For a right shift with effective amount s it is operand bit s-1. For a left shift it is operand bit 128-s.
- R7: At done, sign_o equals result bit 127. ovf_o is 0 for a right shift and is result bit 127 XOR operand bit 127 for a left shift.
- R8: A start is accepted at a clock edge where start_i=1 and busy_o=0. busy_o is then high for four cycles. done_o is high for exactly one cycle, the cycle after the fourth edge following the accepting edge, and busy_o is 0 in that cycle.
- R9: start_i while busy_o=1 is ignored: the running operation completes with its own operand and controls, and no extra done pulse follows.
- R10: result_o and the flags hold their values from done until the next start is accepted.
- R11: After reset, busy_o, done_o, result_o and all four flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, accepted when idle |
| operand_i | input | 128 | Source operand, latched at start |
| amount_i | input | 8 | Shift amount, latched at start |
| left_i | input | 1 | 1 = shift left, 0 = shift right |
| arith_i | input | 1 | 1 = sign fill on a right shift |
| clamp_i | input | 1 | 1 = clamp amount to 128, 0 = wrap modulo 128 |
| result_o | output | 128 | Shifted result |
| zero_o | output | 1 | Whole result is zero |
| carry_o | output | 1 | Last bit shifted out |
| sign_o | output | 1 | Result bit 127 |
| ovf_o | output | 1 | Left shift changed bit 127 |
| busy_o | output | 1 | Sequence running |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The hardest case to reach is a zero flag whose outcome depends on only one of the four word steps. This means results where exactly one word is nonzero, and in particular one where the only nonzero word is written by the last step. Random wide operands almost never produce it. The bench therefore mixes in directed single-bit operands placed in each word, shifted by amounts that leave the bit in a chosen word or push it out entirely. It also drives amounts at 0, 31, 32, 127, 128 and above 128 in both modes, and raises start again in the middle of a running sequence.

// File: rtl/shf_seq_pkg.sv
package shf_seq_pkg;
  typedef struct packed {
    logic zero;
    logic carry;
    logic sign;
    logic ovf;
  } shf_flags_t;
endpackage

// File: rtl/shf_amt_norm.sv
module shf_amt_norm #(
  parameter int TOT_W = 128,
  parameter int AMT_W = 8,
  localparam int LOG_T = $clog2(TOT_W),
  localparam int SH_W  = LOG_T + 1
) (
  input  logic [AMT_W-1:0] amt_i,
  input  logic             clamp_i,
  output logic [SH_W-1:0]  sh_o
);
  always_comb begin
    if (clamp_i) begin
      if (int'(amt_i) > TOT_W) sh_o = SH_W'(TOT_W);
      else                     sh_o = SH_W'(amt_i);
    end else begin
      sh_o = SH_W'(amt_i[LOG_T-1:0]);
    end
  end
endmodule

// File: rtl/shf_funnel_word.sv
module shf_funnel_word #(
  parameter int WORD_W  = 32,
  parameter int N_WORDS = 4,
  localparam int TOT_W  = WORD_W * N_WORDS,
  localparam int SH_W   = $clog2(TOT_W) + 1,
  localparam int LOG_W  = $clog2(WORD_W),
  localparam int STEP_W = $clog2(N_WORDS)
) (
  input  logic [TOT_W-1:0]  op_i,
  input  logic [SH_W-1:0]   sh_i,
  input  logic [STEP_W-1:0] word_i,
  input  logic              left_i,
  input  logic              arith_i,
  output logic [WORD_W-1:0] word_o
);
  function automatic logic [WORD_W-1:0] pick(input logic [TOT_W-1:0] v, input int idx,
                                             input logic [WORD_W-1:0] fill);
    logic [WORD_W-1:0] w;
    w = fill;
    for (int j = 0; j < N_WORDS; j++)
      if (idx == j) w = v[j*WORD_W +: WORD_W];
    return w;
  endfunction

  int                  q;
  int                  k;
  logic [LOG_W-1:0]    r;
  logic [WORD_W-1:0]   fill, hi, lo;
  logic [2*WORD_W-1:0] pair, shr, shl;

  always_comb begin
    q    = int'(sh_i >> LOG_W);
    r    = sh_i[LOG_W-1:0];
    k    = int'(word_i);
    fill = (arith_i && !left_i) ? {WORD_W{op_i[TOT_W-1]}} : '0;
    if (left_i) begin
      hi = pick(op_i, k - q, '0);
      lo = pick(op_i, k - q - 1, '0);
    end else begin
      hi = pick(op_i, k + q + 1, fill);
      lo = pick(op_i, k + q, fill);
    end
    pair = {hi, lo};
    shr  = pair >> r;
    shl  = pair << r;
    word_o = left_i ? shl[2*WORD_W-1:WORD_W] : shr[WORD_W-1:0];
  end
endmodule

// File: rtl/shf_carry_pick.sv
module shf_carry_pick #(
  parameter int TOT_W = 128,
  localparam int SH_W = $clog2(TOT_W) + 1
) (
  input  logic [TOT_W-1:0] op_i,
  input  logic [SH_W-1:0]  sh_i,
  input  logic             left_i,
  output logic             carry_o
);
  int idx;
  always_comb begin
    idx     = left_i ? (TOT_W - int'(sh_i)) : (int'(sh_i) - 1);
    carry_o = 1'b0;
    if (sh_i != '0)
      for (int j = 0; j < TOT_W; j++)
        if (j == idx) carry_o = op_i[j];
  end
endmodule

// File: rtl/shf_flag_acc.sv
module shf_flag_acc
  import shf_seq_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              first_i,
  input  logic              msw_i,
  input  logic              left_i,
  input  logic              op_msb_i,
  input  logic              carry_i,
  input  logic [WORD_W-1:0] word_i,
  output shf_flags_t        flags_o
);
  shf_flags_t fl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fl_q <= '0;
    end else if (en_i) begin
      fl_q.zero <= (word_i == '0) && (first_i || fl_q.zero);
      if (first_i) begin
        fl_q.carry <= carry_i;
        fl_q.sign  <= 1'b0;
        fl_q.ovf   <= 1'b0;
      end
      // step holding the top word owns sign and overflow
      if (msw_i) begin
        fl_q.sign <= word_i[WORD_W-1];
        fl_q.ovf  <= left_i && (word_i[WORD_W-1] ^ op_msb_i);
      end
    end
  end

  assign flags_o = fl_q;
endmodule

// File: rtl/shf_seq.sv
module shf_seq
  import shf_seq_pkg::*;
#(
  parameter int WORD_W  = 32,
  parameter int N_WORDS = 4,
  parameter int AMT_W   = 8,
  localparam int TOT_W  = WORD_W * N_WORDS,
  localparam int SH_W   = $clog2(TOT_W) + 1,
  localparam int STEP_W = $clog2(N_WORDS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [TOT_W-1:0] operand_i,
  input  logic [AMT_W-1:0] amount_i,
  input  logic             left_i,
  input  logic             arith_i,
  input  logic             clamp_i,
  output logic [TOT_W-1:0] result_o,
  output logic             zero_o,
  output logic             carry_o,
  output logic             sign_o,
  output logic             ovf_o,
  output logic             busy_o,
  output logic             done_o
);
  logic [TOT_W-1:0]  op_q, res_q;
  logic [SH_W-1:0]   sh_d, sh_q;
  logic              left_q, arith_q, busy_q, done_q;
  logic [STEP_W-1:0] step_q, word_k;
  logic [WORD_W-1:0] word_w;
  logic              carry_w, accept, last_step;
  shf_flags_t        flags;

  assign accept    = start_i && !busy_q;
  assign last_step = (step_q == STEP_W'(N_WORDS - 1));
  assign word_k    = left_q ? (STEP_W'(N_WORDS - 1) - step_q) : step_q;

  shf_amt_norm #(.TOT_W(TOT_W), .AMT_W(AMT_W)) u_norm (
    .amt_i(amount_i), .clamp_i(clamp_i), .sh_o(sh_d)
  );

  shf_funnel_word #(.WORD_W(WORD_W), .N_WORDS(N_WORDS)) u_funnel (
    .op_i(op_q), .sh_i(sh_q), .word_i(word_k), .left_i(left_q),
    .arith_i(arith_q), .word_o(word_w)
  );

  shf_carry_pick #(.TOT_W(TOT_W)) u_carry (
    .op_i(op_q), .sh_i(sh_q), .left_i(left_q), .carry_o(carry_w)
  );

  shf_flag_acc #(.WORD_W(WORD_W)) u_flags (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(busy_q),
    .first_i(step_q == '0), .msw_i(word_k == STEP_W'(N_WORDS - 1)),
    .left_i(left_q), .op_msb_i(op_q[TOT_W-1]), .carry_i(carry_w),
    .word_i(word_w), .flags_o(flags)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q    <= '0;
      sh_q    <= '0;
      left_q  <= 1'b0;
      arith_q <= 1'b0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      step_q  <= '0;
      res_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        op_q    <= operand_i;
        sh_q    <= sh_d;
        left_q  <= left_i;
        arith_q <= arith_i;
        busy_q  <= 1'b1;
        step_q  <= '0;
      end else if (busy_q) begin
        res_q[int'(word_k)*WORD_W +: WORD_W] <= word_w;
        step_q <= step_q + 1'b1;
        if (last_step) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign result_o = res_q;
  assign zero_o   = flags.zero;
  assign carry_o  = flags.carry;
  assign sign_o   = flags.sign;
  assign ovf_o    = flags.ovf;
  assign busy_o   = busy_q;
  assign done_o   = done_q;
endmodule

// File: rtl/shf_seq_chk.sv
module shf_seq_chk #(
  parameter int TOT_W = 128
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             busy_o,
  input logic             done_o,
  input logic [TOT_W-1:0] result_o,
  input logic             zero_o,
  input logic             sign_o,
  input logic             ovf_o,
  input logic             left_q
);
  a_r8_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r8_done_ends_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ($past(busy_o) && !busy_o));
  a_r8_start_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o);
  a_r8_busy_min: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |=> busy_o);
  a_r5_zero_whole: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (zero_o == (result_o == '0)));
  a_r7_sign_msb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (sign_o == result_o[TOT_W-1]));
  a_r7_right_no_ovf: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !left_q) |-> !ovf_o);
  a_r10_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> $stable(result_o));
endmodule

bind shf_seq shf_seq_chk #(.TOT_W(TOT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .busy_o(busy_o),
  .done_o(done_o), .result_o(result_o), .zero_o(zero_o), .sign_o(sign_o),
  .ovf_o(ovf_o), .left_q(left_q)
);

// File: tb/sim_shf_seq.sv
module sim_shf_seq;
  localparam int CLK_P = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [127:0] op = '0;
  logic [7:0]   amt = '0;
  logic         left = 1'b0, arith = 1'b0, clamp = 1'b0;
  logic [127:0] res;
  logic         zero, carry, sign, ovf, busy, done;
  int           total = 0, bad = 0;
  bit           finished = 0;

  always #(CLK_P/2) clk = ~clk;

  shf_seq u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .operand_i(op), .amount_i(amt),
    .left_i(left), .arith_i(arith), .clamp_i(clamp), .result_o(res),
    .zero_o(zero), .carry_o(carry), .sign_o(sign), .ovf_o(ovf),
    .busy_o(busy), .done_o(done)
  );

  function automatic int eff(logic [7:0] a, logic c);
    if (c) return (int'(a) > 128) ? 128 : int'(a);
    return int'(a[6:0]);
  endfunction

  function automatic logic [127:0] exp_res(logic [127:0] v, int s, logic l, logic ar);
    if (l) return v << s;
    if (ar) return 128'($signed(v) >>> s);
    return v >> s;
  endfunction

  function automatic logic exp_carry(logic [127:0] v, int s, logic l);
    if (s == 0) return 1'b0;
    return l ? v[128 - s] : v[s - 1];
  endfunction

  task automatic chk(string tag, logic [127:0] act, logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // poke=1 raises start again with other inputs while busy (R9)
  task automatic run_op(logic [127:0] v, logic [7:0] a, logic l, logic ar, logic c, bit poke);
    int s, lat;
    logic [127:0] e;
    string tag;
    s = eff(a, c);
    e = exp_res(v, s, l, ar);
    @(negedge clk);
    op = v; amt = a; left = l; arith = ar; clamp = c; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    if (poke) begin
      op = ~v; amt = a + 8'd5; left = ~l; arith = ~ar; start = 1'b1;
    end
    while (!done && lat < 20) begin
      @(negedge clk);
      start = 1'b0;
      lat++;
    end
    tag = l ? "R3 left result" : (ar ? "R2 arith right result" : "R1 logical right result");
    chk(tag, res, e);
    chk("R5 zero flag", 128'(zero), 128'(e == '0));
    chk("R6 carry flag", 128'(carry), 128'(exp_carry(v, s, l)));
    chk("R7 sign flag", 128'(sign), 128'(e[127]));
    chk("R7 overflow flag", 128'(ovf), 128'(l & (e[127] ^ v[127])));
    chk("R8 done latency", 128'(lat), 128'(5));
    chk("R8 busy low at done", 128'(busy), 128'(0));
    @(negedge clk);
    chk("R8 done one cycle", 128'(done), 128'(0));
    if (poke) begin
      for (int i = 0; i < 5; i++) begin
        @(negedge clk);
        chk("R9 no extra done", 128'(done | busy), 128'(0));
      end
      chk("R9 result of first op", res, e);
    end
  endtask

  initial begin
    #(CLK_P * 190000);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [127:0] v, kept;
    void'($urandom(32'd4417));
    #(CLK_P * 2 + 2);
    chk("R11 reset result", res, '0);
    chk("R11 reset flags", 128'({zero, carry, sign, ovf}), '0);
    chk("R11 reset busy/done", 128'({busy, done}), '0);
    rst_n = 1'b1;

    v = {32'h8123_4567, 32'h89ab_cdef, 32'h0fed_cba9, 32'h7654_3210};
    run_op(v, 8'd0, 1'b0, 1'b0, 1'b1, 0);
    run_op(v, 8'd31, 1'b0, 1'b1, 1'b1, 0);
    run_op(v, 8'd32, 1'b1, 1'b0, 1'b1, 0);
    run_op(v, 8'd127, 1'b0, 1'b1, 1'b0, 0);
    run_op(v, 8'd127, 1'b1, 1'b0, 1'b0, 0);
    run_op(v, 8'd200, 1'b0, 1'b1, 1'b1, 0);
    chk("R4 clamp 200 to 128 arith", res, {128{1'b1}});
    run_op(v, 8'd200, 1'b0, 1'b0, 1'b0, 0);
    chk("R4 wrap 200 to 72", res, v >> 72);
    run_op(v, 8'd128, 1'b1, 1'b0, 1'b0, 0);
    chk("R4 wrap 128 to 0", res, v);
    run_op(v, 8'd128, 1'b1, 1'b1, 1'b1, 0);
    chk("R4 clamp 128 left", res, '0);

    // single set bit in each word, kept or pushed out (R5)
    for (int w = 0; w < 4; w++) begin
      run_op(128'(1) << (w * 32 + 5), 8'd5, 1'b0, 1'b0, 1'b1, 0);
      run_op(128'(1) << (w * 32 + 5), 8'd6 + 8'(w * 32), 1'b0, 1'b0, 1'b1, 0);
      run_op(128'(1) << (w * 32 + 5), 8'(96 - w * 32), 1'b1, 1'b0, 1'b1, 0);
      run_op(128'(1) << (w * 32 + 5), 8'(123 - w * 32), 1'b1, 1'b0, 1'b1, 0);
    end

    run_op(v, 8'd40, 1'b0, 1'b1, 1'b1, 1);
    run_op(v, 8'd9, 1'b1, 1'b0, 1'b0, 1);

    kept = res;
    repeat (6) @(negedge clk);
    chk("R10 result held", res, kept);
    chk("R10 flags held", 128'({zero, carry, sign, ovf}),
        128'({kept == '0, exp_carry(v, 9, 1'b1), kept[127], kept[127] ^ v[127]}));

    for (int n = 0; n < 400; n++) begin
      logic [7:0] a;
      case ($urandom % 4)
        0: v = {$urandom, $urandom, $urandom, $urandom};
        1: v = 128'($urandom) << ($urandom % 128);
        2: v = {$urandom, 96'd0} | 128'($urandom % 4);
        default: v = '0;
      endcase
      a = ($urandom % 3 == 0) ? 8'($urandom) : 8'($urandom % 130);
      run_op(v, a, 1'($urandom), 1'($urandom), 1'($urandom), ($urandom % 16) == 0);
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule